// File: doc/BRIEF.md
# Zero-Extending Load Unit with Stack Pop

This block carries out the load instructions of a 32-bit RISC core with sixteen general registers. It takes a 16-bit instruction word together with the current values of the index register Rj and of the three fixed base registers R13, R14 and R15. From these it forms an effective address. It then runs one word, halfword or byte read over a request/acknowledge memory port. The returned unit is widened to 32 bits with zeros in the upper bits and written to its destination.

Three addressing families are supported. The register forms use Rj alone or R13 plus Rj. The frame-relative form adds to R14 a signed 8-bit offset, scaled by the access size. The stack-relative form adds to R15 an unsigned 4-bit offset, scaled by four.

The stack pop forms read the word at R15 and advance R15 by 4. A pop can write a general register, one of six special registers, or the processor status word. The status word carries the condition flags, and the status-word pop is the only load that changes them.

The caller presents the Rj value selected by instruction bits [7:4] and holds all inputs steady while `start` is high. A load is accepted only in a cycle where `ready` is high.

Top module: `lda_load_unit`

## Requirements
- R1: Opcode byte (bits [15:8]) 0x04/0x05/0x06 loads word/halfword/byte from Rj. Opcode byte 0x00/0x01/0x02 loads word/halfword/byte from R13+Rj. In both, Rj is named by bits [7:4] and the destination general register by bits [3:0].
- R2: Top nibble 0x2/0x4/0x6 loads word/halfword/byte from R14 plus the signed 8-bit field in bits [11:4]. The field is scaled by 4, 2 or 1 to match the access size. The destination is bits [3:0].
- R3: Opcode byte 0x03 loads a word from R15 plus four times the unsigned field in bits [7:4]. The destination is bits [3:0].
- R4: `mem_size` is 2 for word, 1 for halfword and 0 for byte. `mem_addr` has bits [1:0] cleared for a word and bit 0 cleared for a halfword. A byte address is left unchanged.
- R5: A byte load writes `mem_rdata[7:0]` and a halfword load writes `mem_rdata[15:0]`, each with zeros in all upper bits. A word load writes all 32 bits.
- R6: `mem_req` rises in the cycle after acceptance. It stays high with a stable address until the cycle in which `mem_ack` is sampled high, so the number of request cycles equals the memory latency. Except for the status-word pop, the result write strobes are high in the cycle after that acknowledge.
- R7: Opcode byte 0x07 with sub-code bits [7:4] = 0 reads the word at R15. In the same cycle it writes that word to general register bits [3:0] and asserts `r15_we` with R15+4.
- R8: When that pop names register 15, the loaded word is written through the general port and `r15_we` stays low.
- R9: Sub-code 8 pops to the special register selected by bits [3:0] (0 to 5, presented on `spr_sel`) and advances R15 by 4. Selector values 6 to 15 make the word unrecognized.
- R10: Sub-code 9 pops the whole word, flags included, to `ps_data` and advances R15 by 4. Its write strobes arrive two cycles after the acknowledge, one cycle later than any other load.
- R11: Only the status-word pop asserts `ps_we`, so every other load leaves the flags untouched. Each write strobe is high for exactly one cycle per load.
- R12: An unrecognized instruction word never raises `mem_req` and leaves `ready` high. `start` is ignored while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction valid |
| instr | input | 16 | Load instruction word |
| rj_val | input | 32 | Value of register selected by instr[7:4] |
| r13_val | input | 32 | Value of R13 |
| r14_val | input | 32 | Value of R14 |
| r15_val | input | 32 | Value of R15 (stack pointer) |
| ready | output | 1 | Idle, can accept a load |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Aligned read address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, addressed unit in low bits |
| gpr_we | output | 1 | General register write strobe |
| gpr_idx | output | 4 | General register index |
| gpr_data | output | 32 | General register write data |
| r15_we | output | 1 | Stack pointer increment strobe |
| r15_data | output | 32 | New stack pointer value |
| spr_we | output | 1 | Special register write strobe |
| spr_sel | output | 3 | Special register selector |
| spr_data | output | 32 | Special register write data |
| ps_we | output | 1 | Status word write strobe |
| ps_data | output | 32 | Status word write data |

## Verification
In one write-back cycle, the general-register write of the loaded word and the stack-pointer post-increment can both target R15. The bench provokes this with a pop whose destination field is 15, set beside an ordinary pop to register 6. It judges the pair at the ports: the loaded word must appear on the general port with index 15, and `r15_we` must stay low, while the ordinary pop raises both strobes together.

// File: rtl/lda_pkg.sv
package lda_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        AM_RJ,
        AM_R13RJ,
        AM_R14,
        AM_R15,
        AM_POP
    } amode_e;

    typedef enum logic [1:0] {
        DS_GPR,
        DS_SPR,
        DS_PS
    } dest_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PSX,
        ST_WB
    } state_e;

    typedef struct packed {
        logic       valid;
        size_e      size;
        amode_e     mode;
        dest_e      dest;
        logic [3:0] dst;
        logic [7:0] off8;
        logic [3:0] off4;
    } dec_t;

endpackage

// File: rtl/lda_decode.sv
module lda_decode
    import lda_pkg::*;
#(
    parameter int SPR_COUNT = 6
) (
    input  logic [15:0] instr,
    output dec_t        dec
);

    localparam logic [3:0] SPR_LIMIT = 4'(SPR_COUNT);

    always_comb begin
        dec       = '0;
        dec.size  = SZ_WORD;
        dec.mode  = AM_RJ;
        dec.dest  = DS_GPR;
        dec.dst   = instr[3:0];
        dec.off8  = instr[11:4];
        dec.off4  = instr[7:4];
        case (instr[15:12])
            4'h2: begin dec.valid = 1'b1; dec.size = SZ_WORD; dec.mode = AM_R14; end
            4'h4: begin dec.valid = 1'b1; dec.size = SZ_HALF; dec.mode = AM_R14; end
            4'h6: begin dec.valid = 1'b1; dec.size = SZ_BYTE; dec.mode = AM_R14; end
            4'h0: begin
                case (instr[11:8])
                    4'h4: begin dec.valid = 1'b1; dec.size = SZ_WORD; dec.mode = AM_RJ;    end
                    4'h5: begin dec.valid = 1'b1; dec.size = SZ_HALF; dec.mode = AM_RJ;    end
                    4'h6: begin dec.valid = 1'b1; dec.size = SZ_BYTE; dec.mode = AM_RJ;    end
                    4'h0: begin dec.valid = 1'b1; dec.size = SZ_WORD; dec.mode = AM_R13RJ; end
                    4'h1: begin dec.valid = 1'b1; dec.size = SZ_HALF; dec.mode = AM_R13RJ; end
                    4'h2: begin dec.valid = 1'b1; dec.size = SZ_BYTE; dec.mode = AM_R13RJ; end
                    4'h3: begin dec.valid = 1'b1; dec.size = SZ_WORD; dec.mode = AM_R15;   end
                    4'h7: begin
                        dec.mode = AM_POP;
                        case (instr[7:4])
                            4'h0: begin dec.valid = 1'b1; dec.dest = DS_GPR; end
                            4'h8: begin
                                dec.valid = (instr[3:0] < SPR_LIMIT);
                                dec.dest  = DS_SPR;
                            end
                            4'h9: begin dec.valid = 1'b1; dec.dest = DS_PS; end
                            default: dec.valid = 1'b0;
                        endcase
                    end
                    default: dec.valid = 1'b0;
                endcase
            end
            default: dec.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lda_agen.sv
module lda_agen
    import lda_pkg::*;
#(
    parameter int DW = 32
) (
    input  dec_t          dec,
    input  logic [DW-1:0] rj_val,
    input  logic [DW-1:0] r13_val,
    input  logic [DW-1:0] r14_val,
    input  logic [DW-1:0] r15_val,
    output logic [DW-1:0] addr
);

    logic [DW-1:0] soff;
    logic [DW-1:0] uoff;
    logic [DW-1:0] raw;
    logic [DW-1:0] low_mask;

    always_comb begin
        // signed frame offset scaled by the access size (shift = size code)
        soff     = {{(DW-8){dec.off8[7]}}, dec.off8} << dec.size;
        uoff     = {{(DW-6){1'b0}}, dec.off4, 2'b00};
        case (dec.mode)
            AM_RJ:    raw = rj_val;
            AM_R13RJ: raw = r13_val + rj_val;
            AM_R14:   raw = r14_val + soff;
            AM_R15:   raw = r15_val + uoff;
            default:  raw = r15_val;
        endcase
        low_mask = (DW'(1) << dec.size) - DW'(1);
        addr     = raw & ~low_mask;
    end

endmodule

// File: rtl/lda_extend.sv
module lda_extend
    import lda_pkg::*;
#(
    parameter int DW = 32
) (
    input  size_e         size,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] value
);

    always_comb begin
        case (size)
            SZ_BYTE: value = DW'(rdata[7:0]);
            SZ_HALF: value = DW'(rdata[15:0]);
            default: value = rdata;
        endcase
    end

endmodule

// File: rtl/lda_load_unit.sv
module lda_load_unit
    import lda_pkg::*;
#(
    parameter int DW        = lda_pkg::XLEN,
    parameter int SPR_COUNT = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [15:0]                  instr,
    input  logic [DW-1:0]                rj_val,
    input  logic [DW-1:0]                r13_val,
    input  logic [DW-1:0]                r14_val,
    input  logic [DW-1:0]                r15_val,
    output logic                         ready,
    output logic                         mem_req,
    output logic [DW-1:0]                mem_addr,
    output logic [1:0]                   mem_size,
    input  logic                         mem_ack,
    input  logic [DW-1:0]                mem_rdata,
    output logic                         gpr_we,
    output logic [3:0]                   gpr_idx,
    output logic [DW-1:0]                gpr_data,
    output logic                         r15_we,
    output logic [DW-1:0]                r15_data,
    output logic                         spr_we,
    output logic [$clog2(SPR_COUNT)-1:0] spr_sel,
    output logic [DW-1:0]                spr_data,
    output logic                         ps_we,
    output logic [DW-1:0]                ps_data
);

    localparam int SELW = $clog2(SPR_COUNT);
    localparam logic [DW-1:0] SP_STEP = DW'(4);

    typedef struct packed {
        state_e        state;
        size_e         size;
        logic          pop;
        dest_e         dest;
        logic [3:0]    dst;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] sp_next;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    dec_t          dec;
    logic [DW-1:0] ea;
    logic [DW-1:0] ext;
    logic          wb;

    lda_decode #(.SPR_COUNT(SPR_COUNT)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    lda_agen #(.DW(DW)) u_agen (
        .dec     (dec),
        .rj_val  (rj_val),
        .r13_val (r13_val),
        .r14_val (r14_val),
        .r15_val (r15_val),
        .addr    (ea)
    );

    lda_extend #(.DW(DW)) u_ext (
        .size  (ctl_q.size),
        .rdata (mem_rdata),
        .value (ext)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start && dec.valid) begin
                    ctl_d.state   = ST_WAIT;
                    ctl_d.size    = dec.size;
                    ctl_d.pop     = (dec.mode == AM_POP);
                    ctl_d.dest    = dec.dest;
                    ctl_d.dst     = dec.dst;
                    ctl_d.addr    = ea;
                    ctl_d.sp_next = r15_val + SP_STEP;
                end
            end
            ST_WAIT: begin
                if (mem_ack) begin
                    ctl_d.data  = ext;
                    ctl_d.state = (ctl_q.dest == DS_PS) ? ST_PSX : ST_WB;
                end
            end
            ST_PSX:  ctl_d.state = ST_WB;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wb       = (ctl_q.state == ST_WB);
    assign ready    = (ctl_q.state == ST_IDLE);
    assign mem_req  = (ctl_q.state == ST_WAIT);
    assign mem_addr = ctl_q.addr;
    assign mem_size = ctl_q.size;

    assign gpr_we   = wb && (ctl_q.dest == DS_GPR);
    assign gpr_idx  = ctl_q.dst;
    assign gpr_data = ctl_q.data;
    // loaded value wins over the post-increment when a pop targets R15
    assign r15_we   = wb && ctl_q.pop && !((ctl_q.dest == DS_GPR) && (ctl_q.dst == 4'hF));
    assign r15_data = ctl_q.sp_next;
    assign spr_we   = wb && (ctl_q.dest == DS_SPR);
    assign spr_sel  = ctl_q.dst[SELW-1:0];
    assign spr_data = ctl_q.data;
    assign ps_we    = wb && (ctl_q.dest == DS_PS);
    assign ps_data  = ctl_q.data;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R6
    AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R6
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size == 2'd2 ? mem_addr[1:0] == 2'b00 :
                     mem_size == 2'd1 ? mem_addr[0] == 1'b0 : 1'b1)); // R4
    AST_R15_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we && gpr_idx == 4'hF |-> !r15_we); // R8
    AST_PS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ps_we |-> !gpr_we && !spr_we && r15_we); // R11
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_we || spr_we || ps_we) |=> !(gpr_we || spr_we || ps_we)); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ready); // R12
    AST_WRITE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_we, spr_we, ps_we})); // R11

endmodule

// File: tb/lda_load_unit_tb.sv
module lda_load_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] rj_val = '0, r13_val = '0, r14_val = '0, r15_val = '0;
    logic        ready, mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        gpr_we, r15_we, spr_we, ps_we;
    logic [3:0]  gpr_idx;
    logic [2:0]  spr_sel;
    logic [31:0] gpr_data, r15_data, spr_data, ps_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] got_addr;
    logic [1:0]  got_size;
    int          req_cycles, wb_delay;
    bit          addr_moved, req_after_ack, extra_pulse;
    logic        c_gpr_we, c_r15_we, c_spr_we, c_ps_we;
    logic [3:0]  c_gpr_idx;
    logic [2:0]  c_spr_sel;
    logic [31:0] c_gpr_data, c_r15_data, c_spr_data, c_ps_data;

    always #2 clk = ~clk;

    lda_load_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rj_val(rj_val), .r13_val(r13_val), .r14_val(r14_val), .r15_val(r15_val),
        .ready(ready), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .r15_we(r15_we), .r15_data(r15_data),
        .spr_we(spr_we), .spr_sel(spr_sel), .spr_data(spr_data),
        .ps_we(ps_we), .ps_data(ps_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Serve the request after lat cycles, then find the write cycle.
    task automatic serve(input logic [31:0] rdata, input int lat);
        logic [31:0] a0;
        req_cycles = 0; addr_moved = 0; wb_delay = 0;
        c_gpr_we = 0; c_r15_we = 0; c_spr_we = 0; c_ps_we = 0;
        if (!mem_req) return;
        a0 = mem_addr;
        for (int i = 1; i < lat; i++) begin
            req_cycles++;
            @(negedge clk);
            if (mem_addr !== a0 || !mem_req) addr_moved = 1;
        end
        mem_ack = 1; mem_rdata = rdata;
        got_addr = mem_addr; got_size = mem_size;
        req_cycles++;
        @(negedge clk);
        mem_ack = 0;
        req_after_ack = mem_req;
        for (int k = 1; k <= 4; k++) begin
            if (gpr_we || r15_we || spr_we || ps_we) begin
                wb_delay = k;
                c_gpr_we = gpr_we; c_gpr_idx = gpr_idx; c_gpr_data = gpr_data;
                c_r15_we = r15_we; c_r15_data = r15_data;
                c_spr_we = spr_we; c_spr_sel = spr_sel; c_spr_data = spr_data;
                c_ps_we = ps_we; c_ps_data = ps_data;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        extra_pulse = gpr_we || r15_we || spr_we || ps_we;
    endtask

    task automatic do_load(input logic [15:0] iw, input logic [31:0] rj, input logic [31:0] r13,
                           input logic [31:0] r14, input logic [31:0] r15,
                           input logic [31:0] rdata, input int lat);
        @(negedge clk);
        instr = iw; rj_val = rj; r13_val = r13; r14_val = r14; r15_val = r15; start = 1;
        @(negedge clk);
        start = 0;
        serve(rdata, lat);
    endtask

    task automatic t_reset();
        check(ready === 1'b1, "R12 reset ready", 32'(ready), 32'd1);
        check(mem_req === 1'b0, "R6 reset no request", 32'(mem_req), 32'd0);
        check({gpr_we, r15_we, spr_we, ps_we} === 4'b0, "R11 reset strobes", 32'({gpr_we, r15_we, spr_we, ps_we}), 32'd0);
    endtask

    task automatic t_rj_word();
        do_load(16'h0453, 32'h1000_0006, 0, 0, 0, 32'hDEAD_BEEF, 3);
        check(got_addr == 32'h1000_0004, "R1/R4 rj word addr", got_addr, 32'h1000_0004);
        check(got_size == 2'd2, "R4 word size", 32'(got_size), 32'd2);
        check(req_cycles == 3 && !addr_moved, "R6 request cycles", 32'(req_cycles), 32'd3);
        check(!req_after_ack, "R6 request drops", 32'(req_after_ack), 32'd0);
        check(wb_delay == 1, "R6 write delay", 32'(wb_delay), 32'd1);
        check(c_gpr_we && c_gpr_idx == 4'd3 && c_gpr_data == 32'hDEAD_BEEF, "R1 rj word data", c_gpr_data, 32'hDEAD_BEEF);
        check(!c_ps_we && !c_r15_we && !extra_pulse, "R11 no flag write", 32'({c_ps_we, c_r15_we, extra_pulse}), 32'd0);
    endtask

    task automatic t_r13_word();
        do_load(16'h0012, 32'h10, 32'h2000, 0, 0, 32'h0102_0304, 1);
        check(got_addr == 32'h2010, "R1 r13+rj addr", got_addr, 32'h2010);
        check(req_cycles == 1, "R6 single-cycle latency", 32'(req_cycles), 32'd1);
        check(c_gpr_we && c_gpr_idx == 4'd2 && c_gpr_data == 32'h0102_0304, "R1 r13+rj data", c_gpr_data, 32'h0102_0304);
    endtask

    task automatic t_r14_forms();
        do_load(16'h2FF7, 0, 0, 32'h3000, 0, 32'h5555_AAAA, 2);
        check(got_addr == 32'h2FFC, "R2 r14 word negative", got_addr, 32'h2FFC);
        check(c_gpr_idx == 4'd7 && c_gpr_data == 32'h5555_AAAA, "R2 r14 word data", c_gpr_data, 32'h5555_AAAA);
        do_load(16'h4031, 0, 0, 32'h3000, 0, 32'hFFFF_8001, 2);
        check(got_addr == 32'h3006 && got_size == 2'd1, "R2 r14 half scaled", got_addr, 32'h3006);
        check(c_gpr_data == 32'h0000_8001, "R5 half zero-extend", c_gpr_data, 32'h0000_8001);
        do_load(16'h6805, 0, 0, 32'h3001, 0, 32'h1234_56A5, 2);
        check(got_addr == 32'h2F81 && got_size == 2'd0, "R2/R4 r14 byte -128 unaligned", got_addr, 32'h2F81);
        check(c_gpr_idx == 4'd5 && c_gpr_data == 32'h0000_00A5, "R5 byte zero-extend", c_gpr_data, 32'h0000_00A5);
    endtask

    task automatic t_half_align();
        do_load(16'h0594, 32'h5003, 0, 0, 0, 32'hABCD_1234, 2);
        check(got_addr == 32'h5002 && got_size == 2'd1, "R4 half align", got_addr, 32'h5002);
        check(c_gpr_idx == 4'd4 && c_gpr_data == 32'h0000_1234, "R5 half rj data", c_gpr_data, 32'h0000_1234);
    endtask

    task automatic t_r15_rel();
        do_load(16'h03F6, 0, 0, 0, 32'h8000, 32'h0BAD_F00D, 2);
        check(got_addr == 32'h803C, "R3 r15 udisp max", got_addr, 32'h803C);
        check(c_gpr_idx == 4'd6 && !c_r15_we, "R3 no sp change", 32'(c_r15_we), 32'd0);
    endtask

    task automatic t_pop_gpr();
        do_load(16'h0706, 0, 0, 0, 32'h9000, 32'h7777_0001, 2);
        check(got_addr == 32'h9000 && got_size == 2'd2, "R7 pop addr", got_addr, 32'h9000);
        check(c_gpr_we && c_gpr_idx == 4'd6 && c_gpr_data == 32'h7777_0001, "R7 pop data", c_gpr_data, 32'h7777_0001);
        check(c_r15_we && c_r15_data == 32'h9004, "R7 sp increment", c_r15_data, 32'h9004);
    endtask

    task automatic t_pop_r15();
        do_load(16'h070F, 0, 0, 0, 32'hA000, 32'h4444_0000, 2);
        check(c_gpr_we && c_gpr_idx == 4'hF && c_gpr_data == 32'h4444_0000, "R8 pop r15 data", c_gpr_data, 32'h4444_0000);
        check(!c_r15_we, "R8 increment suppressed", 32'(c_r15_we), 32'd0);
    endtask

    task automatic t_pop_spr();
        do_load(16'h0783, 0, 0, 0, 32'hB000, 32'h1357_9BDF, 2);
        check(c_spr_we && c_spr_sel == 3'd3 && c_spr_data == 32'h1357_9BDF, "R9 spr data", c_spr_data, 32'h1357_9BDF);
        check(!c_gpr_we && c_r15_we && c_r15_data == 32'hB004, "R9 sp increment", c_r15_data, 32'hB004);
    endtask

    task automatic t_pop_ps();
        do_load(16'h0790, 0, 0, 0, 32'hC000, 32'hF000_000F, 3);
        check(wb_delay == 2, "R10 extra cycle", 32'(wb_delay), 32'd2);
        check(c_ps_we && c_ps_data == 32'hF000_000F, "R10 ps data", c_ps_data, 32'hF000_000F);
        check(!c_gpr_we && !c_spr_we && c_r15_we && c_r15_data == 32'hC004, "R10 sp increment", c_r15_data, 32'hC004);
        check(!extra_pulse, "R11 single strobe", 32'(extra_pulse), 32'd0);
    endtask

    task automatic t_drop(input logic [15:0] iw);
        bit seen;
        seen = 0;
        @(negedge clk);
        instr = iw; start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 4; i++) begin
            if (mem_req || !ready || gpr_we || spr_we || ps_we) seen = 1;
            @(negedge clk);
        end
        check(!seen, "R12 unrecognized dropped", 32'(iw), 32'd0);
    endtask

    task automatic t_busy_ignored();
        @(negedge clk);
        instr = 16'h0453; rj_val = 32'h100; r13_val = 0; start = 1;
        @(negedge clk);
        instr = 16'h0012; rj_val = 32'h200; r13_val = 32'h40;
        @(negedge clk);
        start = 0;
        serve(32'h2468_ACE0, 1);
        check(got_addr == 32'h100, "R12 start ignored while busy", got_addr, 32'h100);
        check(c_gpr_idx == 4'd3 && !mem_req && ready, "R12 no second load", 32'(mem_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rj_word();
        t_r13_word();
        t_r14_forms();
        t_half_align();
        t_r15_rel();
        t_pop_gpr();
        t_pop_r15();
        t_pop_spr();
        t_pop_ps();
        t_drop(16'h0800);
        t_drop(16'h0787);
        t_busy_ignored();
        finish_report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_report();
    end

endmodule